// File: doc/BRIEF.md
# Windowed Watchdog Timer with Service Key

The block is a watchdog that software must feed in good time. A counter advances on each cycle in which the slow tick enable is high. The block reads a static option byte once, in the first clock after reset is released. That byte decides three things: whether the watchdog runs, which of eight overflow periods applies, and how much of each period lets software service it. Software services the watchdog by writing a one-byte key on an 8-bit write port.

A correct key restarts the count from zero. Any misuse of the port causes a one-cycle reset request, and so does letting the count run out. Misuse is a wrong value, an access flagged as a single-bit operation, or a repeat service outside the open window. The request goes to the surrounding reset logic. After raising a request, the block returns to its post-reset state, with its configuration kept.

Top module: `keyed_watchdog`

## Requirements
- R1: `rst_req` is low during and after reset. The option byte is captured in the first clock after reset release, and later changes to it have no effect.
- R2: With option bit 4 clear, the counter never advances. No tick, no write value and no bit-operation access produces a request.
- R3: Option bits 3..1 hold a code n. With no accepted key, the request is raised after exactly 2^(BASE_EXP+n) cycles with `tick_en` high. Cycles with `tick_en` low are not counted.
- R4: A write of 0xAC that is accepted clears the count to zero, and counting restarts from there. The next overflow needs a full period of ticks.
- R5: A write with any data other than 0xAC raises the request.
- R6: A write with `key_bitop` high raises the request, whatever the data, including 0xAC.
- R7: The first 0xAC write after reset or after a request is accepted at any count. This includes the last count before overflow, even in the same cycle as a tick.
- R8: Option bits 6..5 select the window. Code 0 opens it from half the period, code 1 from a quarter, and codes 2 and 3 keep it always open. A 0xAC write after the first accepted one, made while the window is closed, raises the request. At the first open count it is accepted.
- R9: The request is registered: it is high for one cycle, in the cycle after the edge that sampled its cause. That edge also clears the count, and the next key write is again treated as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow-clock enable; the counter advances on cycles where it is high |
| option_byte | input | 8 | Static configuration: bit 4 run, bits 3..1 period code, bits 6..5 window code |
| key_wr | input | 1 | Single-cycle write strobe to the key register |
| key_data | input | 8 | Data of the key write |
| key_bitop | input | 1 | Marks the write as a single-bit manipulation |
| rst_req | output | 1 | Registered one-cycle internal reset request |

## Verification
The hardest cases to reach are the two edges of the service window. One is a key write at the count just before the window opens, which must be rejected only when an earlier key was accepted. The other is a first key written on the final count together with a tick. The bench reaches both by counting exact tick cycles from a known zero. It first makes a late first service, then counts to one below and exactly at the computed window start before writing. This is repeated for every period and window code with a small base exponent, so that every boundary is met within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] WDT_KEY = 8'hAC;

  typedef struct packed {
    logic       run_en;
    logic [2:0] period_sel;
    logic [1:0] window_sel;
  } wdt_cfg_t;

  function automatic wdt_cfg_t decode_option(input logic [7:0] opt);
    wdt_cfg_t c;
    c.run_en     = opt[4];
    c.period_sel = opt[3:1];
    c.window_sel = opt[6:5];
    return c;
  endfunction

endpackage

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opt_i,
  output wdt_cfg_t   cfg_o,
  output logic       cfg_vld_o
);

  wdt_cfg_t cfg_q, cfg_d;
  logic     vld_q, vld_d;

  always_comb begin
    cfg_d = cfg_q;
    vld_d = vld_q;
    if (!vld_q) begin
      cfg_d = decode_option(opt_i);
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      vld_q <= vld_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign cfg_vld_o = vld_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> (vld_q && $stable(cfg_q))); // R1

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit_i)); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/wdt_period_window.sv
module wdt_period_window
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 7,
  parameter int CNT_W    = BASE_EXP + 7
) (
  input  wdt_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             last_o,
  output logic             open_o
);

  localparam int N_PER = 8;

  logic [CNT_W-1:0] lim_tab [N_PER];

  for (genvar i = 0; i < N_PER; i++) begin : g_period
    localparam int EXP = BASE_EXP + i;
    assign lim_tab[i] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] half_start;
  logic [CNT_W-1:0] quarter_start;

  assign limit         = lim_tab[cfg_i.period_sel];
  assign half_start    = (limit >> 1) + CNT_W'(1);
  assign quarter_start = (limit >> 2) + CNT_W'(1);

  always_comb begin
    case (cfg_i.window_sel)
      2'd0:    open_o = (cnt_i >= half_start);
      2'd1:    open_o = (cnt_i >= quarter_start);
      default: open_o = 1'b1;
    endcase
  end

  assign limit_o = limit;
  assign last_o  = (cnt_i == limit);

endmodule

// File: rtl/wdt_service.sv
module wdt_service
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       wr_i,
  input  logic       bitop_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  input  logic       last_i,
  input  logic       open_i,
  output logic       clr_o,
  output logic       armed_o,
  output logic       req_o
);

  logic armed_q, armed_d;
  logic req_q, req_d;
  logic fault, accept;

  always_comb begin
    fault  = 1'b0;
    accept = 1'b0;
    if (active_i) begin
      if (wr_i) begin
        if (bitop_i || (data_i != WDT_KEY)) begin
          fault = 1'b1;
        end else if (armed_q && !open_i) begin
          fault = 1'b1;
        end else begin
          accept = 1'b1;
        end
      end else if (tick_i && last_i) begin
        fault = 1'b1;
      end
    end
  end

  always_comb begin
    req_d   = fault;
    armed_d = armed_q;
    if (fault) begin
      armed_d = 1'b0;
    end else if (accept) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign clr_o   = fault | accept;
  assign armed_o = armed_q;
  assign req_o   = req_q;

  AST_REQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !armed_q); // R9

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] option_byte,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       key_bitop,
  output logic       rst_req
);

  localparam int CNT_W = BASE_EXP + 7;

  wdt_cfg_t         cfg;
  logic             cfg_vld;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             last_cnt;
  logic             win_open;
  logic             clr;
  logic             armed;

  wdt_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .opt_i     (option_byte),
    .cfg_o     (cfg),
    .cfg_vld_o (cfg_vld)
  );

  assign active = cfg_vld & cfg.run_en;

  wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (active),
    .tick_i  (tick_en),
    .clr_i   (clr),
    .limit_i (limit),
    .cnt_o   (cnt)
  );

  wdt_period_window #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_win (
    .cfg_i   (cfg),
    .cnt_i   (cnt),
    .limit_o (limit),
    .last_o  (last_cnt),
    .open_o  (win_open)
  );

  wdt_service u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .wr_i     (key_wr),
    .bitop_i  (key_bitop),
    .data_i   (key_data),
    .tick_i   (tick_en),
    .last_i   (last_cnt),
    .open_i   (win_open),
    .clr_o    (clr),
    .armed_o  (armed),
    .req_o    (rst_req)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_vld && !cfg.run_en) |-> !rst_req); // R2

  AST_OVERFLOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick_en && last_cnt && !key_wr) |=> rst_req); // R3

  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && key_wr && !key_bitop && key_data == WDT_KEY && (win_open || !armed))
      |=> (cnt == '0 && !rst_req)); // R4

  AST_BAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && key_wr && key_data != WDT_KEY) |=> rst_req); // R5

  AST_BITOP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active && key_wr && key_bitop) |=> rst_req); // R6

  AST_CLOSED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active && key_wr && armed && !win_open) |=> rst_req); // R8

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0)); // R9

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

  localparam int BE = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [7:0] option_byte;
  logic       key_wr;
  logic [7:0] key_data;
  logic       key_bitop;
  logic       rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.BASE_EXP(BE)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .option_byte (option_byte),
    .key_wr      (key_wr),
    .key_data    (key_data),
    .key_bitop   (key_bitop),
    .rst_req     (rst_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] make_opt(input int en, input int per, input int win);
    return {1'b1, 2'(win), 1'(en), 3'(per), 1'b1};
  endfunction

  task automatic go_reset(input logic [7:0] opt);
    tick_en     = 1'b0;
    key_wr      = 1'b0;
    key_bitop   = 1'b0;
    key_data    = 8'h00;
    option_byte = opt;
    rst_n       = 1'b0;
    repeat (2) @(negedge clk);
    check(rst_req == 1'b0, "R1 reset", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Applies n tick cycles; returns index of first tick after which rst_req was seen.
  task automatic run_ticks(input int n, output int first);
    first = 0;
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      if (rst_req && first == 0) first = i + 1;
    end
    tick_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, input logic bop, input logic tk, output logic r);
    key_wr    = 1'b1;
    key_data  = d;
    key_bitop = bop;
    tick_en   = tk;
    @(negedge clk);
    key_wr    = 1'b0;
    key_bitop = 1'b0;
    tick_en   = 1'b0;
    r = rst_req;
  endtask

  task automatic idle_check(input string rq);
    @(negedge clk);
    check(rst_req == 1'b0, rq, int'(rst_req), 0);
  endtask

  initial begin
    int   f;
    logic r;
    int   per_len;
    int   win_start;

    rst_n = 1'b0;
    tick_en = 1'b0;
    key_wr = 1'b0;
    key_bitop = 1'b0;
    key_data = 8'h00;
    option_byte = 8'h00;

    for (int p = 0; p < 8; p++) begin
      for (int w = 0; w < 4; w++) begin
        per_len   = 1 << (BE + p);
        win_start = (w == 0) ? per_len / 2 : (w == 1) ? per_len / 4 : 0;

        // R3: overflow after exactly one period of ticks
        go_reset(make_opt(1, p, w));
        run_ticks(per_len, f);
        check(f == per_len, "R3 overflow tick", f, per_len);
        idle_check("R9 single-cycle pulse");

        // R7: first key at last count with a simultaneous tick
        go_reset(make_opt(1, p, w));
        run_ticks(per_len - 1, f);
        check(f == 0, "R3 no early request", f, 0);
        do_write(8'hAC, 1'b0, 1'b1, r);
        check(r == 1'b0, "R7 first key at last count", int'(r), 0);
        // R4: count restarted from zero
        run_ticks(per_len - 1, f);
        check(f == 0, "R4 restart from zero", f, 0);
        do_write(8'hAC, 1'b0, 1'b0, r);
        check(r == 1'b0, "R8 key at end of period", int'(r), 0);

        // R8: closed-window boundary
        if (win_start > 0) begin
          run_ticks(win_start - 1, f);
          do_write(8'hAC, 1'b0, 1'b0, r);
          check(r == 1'b1, "R8 key one before window", int'(r), 1);
          // R9: next key is first again, at count 0
          do_write(8'hAC, 1'b0, 1'b0, r);
          check(r == 1'b0, "R9 key after request is first", int'(r), 0);
          run_ticks(win_start, f);
          do_write(8'hAC, 1'b0, 1'b0, r);
          check(r == 1'b0, "R8 key at window start", int'(r), 0);
        end else begin
          do_write(8'hAC, 1'b0, 1'b0, r);
          check(r == 1'b0, "R8 always-open key at zero", int'(r), 0);
        end

        // R5: wrong value
        do_write(8'hAC ^ 8'(1 << p), 1'b0, 1'b0, r);
        check(r == 1'b1, "R5 wrong key", int'(r), 1);
        idle_check("R9 pulse after wrong key");
        // R6: bit-op access with the key value
        do_write(8'hAC, 1'b1, 1'b0, r);
        check(r == 1'b1, "R6 bit-op access", int'(r), 1);

        // R2: disabled watchdog stays quiet
        go_reset(make_opt(0, p, w));
        run_ticks(per_len + 3, f);
        check(f == 0, "R2 disabled overflow", f, 0);
        do_write(8'h55, 1'b0, 1'b0, r);
        check(r == 1'b0, "R2 disabled wrong key", int'(r), 0);
        do_write(8'hAC, 1'b1, 1'b0, r);
        check(r == 1'b0, "R2 disabled bit-op", int'(r), 0);
      end
    end

    // R1: option byte changes after capture are ignored
    go_reset(make_opt(1, 0, 2));
    option_byte = make_opt(0, 3, 0);
    run_ticks(1 << BE, f);
    check(f == (1 << BE), "R1 option frozen", f, 1 << BE);

    // R3: cycles with tick_en low are not counted
    go_reset(make_opt(1, 0, 2));
    run_ticks((1 << BE) - 1, f);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(rst_req == 1'b0, "R3 gated cycles not counted", int'(rst_req), 0);
    end
    run_ticks(1, f);
    check(f == 1, "R3 overflow after gap", f, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule